// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. Bytes go into an internal queue through a one-cycle write strobe. A serializer takes them out one at a time and sends each one as a frame. Every bit transition is paced by a one-cycle baud tick that comes from outside, so the bit rate is set by whoever drives that tick.

A small command port controls the transmitter. An enable command starts it. A disable command lets it finish sending what is already queued and then switches it off. A reset command stops it at once and empties the queue. Two flags report its condition to the processor. The ready flag means there is room for another byte. The idle flag means nothing is queued and the last stop bit has been fully sent.

There are two state machines. The control machine has the states OFF, RUN and DRAIN, with these transitions:
- OFF→RUN on enable.
- RUN→DRAIN on disable.
- DRAIN→RUN on enable.
- DRAIN→OFF once the queue is empty and the serializer is idle.
- Any state→OFF on reset.

The serializer has the states SH_IDLE, SH_START, SH_DATA and SH_STOP. It moves only on a baud tick:
- SH_IDLE→SH_START when a byte is available.
- SH_START→SH_DATA.
- SH_DATA→SH_DATA until the eighth bit has been sent, then SH_DATA→SH_STOP.
- SH_STOP→SH_START if another byte is available, otherwise SH_STOP→SH_IDLE.
- A reset command forces SH_IDLE from any state.

Top module: `async_tx_engine`

## Requirements
- R1: After hardware reset the block is in the disabled state. In that state `txd` is 1 and both `tx_ready` and `tx_idle` are 0. Nothing is sent until an enable command arrives.
- R2: A command is taken only in a cycle where `cmd_valid` is 1. The codes for `cmd_code` are: 2'b00 does nothing, 2'b01 enables, 2'b10 disables, 2'b11 resets.
- R3: An enable command given while the block is disabled sets both `tx_ready` and `tx_idle` to 1 in the next cycle.
- R4: Each frame is sent as one start bit at 0, then 8 data bits with the least significant bit first, then one stop bit at 1. `txd` changes only in the cycle after a `baud_tick` or after a reset command. As a result, each bit lasts exactly one tick period.
- R5: `tx_ready` is 1 while the block is enabled and the queue holds fewer than DEPTH bytes. It goes to 0 when the queue is full. A write made while the queue is full is discarded.
- R6: `tx_idle` is 1 only while the block is enabled, the queue is empty and the last stop bit has finished. `tx_idle` is never 1 unless `tx_ready` is also 1.
- R7: A byte written while `tx_idle` is 1 clears `tx_idle` in the next cycle. Its start bit begins at the next `baud_tick`.
- R8: A write made while the block is disabled or draining is discarded. No frame is ever sent for it.
- R9: A reset command does the following in the next cycle: `txd` goes to 1, both flags go to 0, and the queue is emptied, so no queued byte is ever sent.
- R10: A disable command sets both flags to 0 in the next cycle. Every byte already queued is still sent in full, including its stop bit. After that the block enters the disabled state.
- R11: An enable command given during draining cancels the pending shutdown. `tx_ready` returns to 1 in the next cycle, and later writes are accepted and sent.
- R12: When the queue still holds data at the end of a stop bit, the next start bit follows at once. N queued bytes therefore take exactly 10·N tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_en | input | 1 | Write strobe that pushes `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| cmd_valid | input | 1 | Marks `cmd_code` as valid in this cycle |
| cmd_code | input | 2 | Command code (encoding given in R2) |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| txd | output | 1 | Serial output line, held at 1 when nothing is being sent |
| tx_ready | output | 1 | Enabled, with room in the queue |
| tx_idle | output | 1 | Enabled, queue empty and last stop bit finished |

## Verification
If the control state is wrong, it shows on the flags in the cycle right after the command. One example is a drain that never finishes; another is a cancelled disable that still shuts the block down. If the serializer state or bit count is wrong, it shows within one tick period as a frame that cannot be decoded, a missing stop bit, or a line change between ticks. If the queue pointers or count are wrong, the effect appears later. It shows as lost, repeated or reordered bytes in the decoded stream, or as `tx_ready` dropping at the wrong fill level. The bench therefore checks the flags in the cycle after each command. It also decodes every frame and compares the whole byte stream, including a sweep over all 256 byte values.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_RESET   = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        CTL_OFF   = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_e;

endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
    import async_tx_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             baud_tick,
    input  logic             avail,
    input  logic [WIDTH-1:0] din,
    output logic             pop,
    output logic             txd,
    output logic             idle
);

    sh_e              sh_q, sh_n;
    logic [BW-1:0]    bit_q, bit_n;
    logic [WIDTH-1:0] shr_q, shr_n;
    logic             line_q, line_n;

    // next-state logic
    always_comb begin
        sh_n   = sh_q;
        bit_n  = bit_q;
        shr_n  = shr_q;
        line_n = line_q;
        pop    = 1'b0;
        if (abort) begin
            sh_n   = SH_IDLE;
            line_n = 1'b1;
        end else if (baud_tick) begin
            unique case (sh_q)
                SH_IDLE: begin
                    if (avail) begin
                        sh_n   = SH_START;
                        shr_n  = din;
                        line_n = 1'b0;
                        pop    = 1'b1;
                    end
                end
                SH_START: begin
                    sh_n   = SH_DATA;
                    bit_n  = '0;
                    line_n = shr_q[0];
                end
                SH_DATA: begin
                    if (bit_q == BW'(WIDTH - 1)) begin
                        sh_n   = SH_STOP;
                        line_n = 1'b1;
                    end else begin
                        shr_n  = shr_q >> 1;
                        line_n = shr_q[1];
                        bit_n  = bit_q + 1'b1;
                    end
                end
                SH_STOP: begin
                    if (avail) begin
                        sh_n   = SH_START;
                        shr_n  = din;
                        line_n = 1'b0;
                        pop    = 1'b1;
                    end else begin
                        sh_n   = SH_IDLE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= SH_IDLE;
            bit_q  <= '0;
            shr_q  <= '0;
            line_q <= 1'b1;
        end else begin
            sh_q   <= sh_n;
            bit_q  <= bit_n;
            shr_q  <= shr_n;
            line_q <= line_n;
        end
    end

    // outputs
    always_comb begin
        txd  = line_q;
        idle = (sh_q == SH_IDLE);
    end

endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
    import async_tx_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic             baud_tick,
    output logic             txd,
    output logic             tx_ready,
    output logic             tx_idle
);

    ctl_e             ctl_q, ctl_n;
    logic             do_en, do_dis, do_rst;
    logic             q_push, q_pop, q_empty, q_full, sh_idle, sh_avail;
    logic [WIDTH-1:0] q_dout;
    logic [CW-1:0]    q_count;

    always_comb begin
        do_en  = cmd_valid && (cmd_e'(cmd_code) == CMD_ENABLE);
        do_dis = cmd_valid && (cmd_e'(cmd_code) == CMD_DISABLE);
        do_rst = cmd_valid && (cmd_e'(cmd_code) == CMD_RESET);
    end

    // control next state
    always_comb begin
        ctl_n = ctl_q;
        if (do_rst) begin
            ctl_n = CTL_OFF;
        end else begin
            unique case (ctl_q)
                CTL_OFF:   if (do_en) ctl_n = CTL_RUN;
                CTL_RUN:   if (do_dis) ctl_n = CTL_DRAIN;
                CTL_DRAIN: begin
                    if (do_en)                   ctl_n = CTL_RUN;
                    else if (q_empty && sh_idle) ctl_n = CTL_OFF;
                end
                default:   ctl_n = CTL_OFF;
            endcase
        end
    end

    // control state register
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_OFF;
        else        ctl_q <= ctl_n;
    end

    // outputs and datapath steering
    always_comb begin
        q_push   = wr_en && (ctl_q == CTL_RUN);
        sh_avail = !q_empty && (ctl_q != CTL_OFF);
        tx_ready = (ctl_q == CTL_RUN) && !q_full;
        tx_idle  = (ctl_q == CTL_RUN) && q_empty && sh_idle;
    end

    async_tx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (do_rst),
        .push  (q_push),
        .din   (wr_data),
        .pop   (q_pop),
        .dout  (q_dout),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    async_tx_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (do_rst),
        .baud_tick (baud_tick),
        .avail     (sh_avail),
        .din       (q_dout),
        .pop       (q_pop),
        .txd       (txd),
        .idle      (sh_idle)
    );

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk
    import async_tx_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          cmd_valid,
    input logic [1:0]    cmd_code,
    input logic          baud_tick,
    input logic          txd,
    input logic          tx_ready,
    input logic          tx_idle,
    input logic [1:0]    ctl_state,
    input logic [CW-1:0] fifo_count
);

    logic rst_cmd, en_cmd, dis_cmd;
    assign rst_cmd = cmd_valid && (cmd_code == 2'b11);
    assign en_cmd  = cmd_valid && (cmd_code == 2'b01);
    assign dis_cmd = cmd_valid && (cmd_code == 2'b10);

    // R3
    enable_wakes_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && ctl_state == 2'(CTL_OFF)) |=> (tx_ready && tx_idle));

    // R4
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !rst_cmd) |=> $stable(txd));

    // R5
    full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_ready) |=> (fifo_count <= $past(fifo_count)));

    // R6
    idle_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_ready);

    // R9
    reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (txd && !tx_ready && !tx_idle && fifo_count == '0));

    // R10
    disable_drops_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_cmd && ctl_state == 2'(CTL_RUN)) |=> (!tx_ready && !tx_idle));

endmodule

bind async_tx_engine async_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .baud_tick  (baud_tick),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_idle    (tx_idle),
    .ctl_state  (ctl_q),
    .fifo_count (q_count)
);

// File: tb/async_tx_engine_tb.sv
module async_tx_engine_tb;

    localparam int DEPTH = 4;
    localparam int TPER  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = '0;
    logic       baud_tick = 1'b0;
    logic       txd, tx_ready, tx_idle;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic tick_en = 1'b0;
    int div = 0;

    logic seen_tick = 1'b0;
    logic seen_rst = 1'b0;
    logic prev_txd = 1'b1;
    int   glitches = 0;
    int   rx_state = 0;
    logic [7:0] rx_sh = '0;
    int   stop_errs = 0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];
    int   ck_idx = 0;
    int   flush_req = 0;
    int   flush_ack = 0;

    always #5 clk = ~clk;

    async_tx_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .baud_tick(baud_tick),
        .txd(txd), .tx_ready(tx_ready), .tx_idle(tx_idle)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            div = 0;
            baud_tick = 1'b0;
        end else begin
            div = (div + 1) % TPER;
            baud_tick = tick_en && (div == 0);
        end
    end

    always @(posedge clk) begin
        seen_tick <= baud_tick;
        seen_rst  <= cmd_valid && (cmd_code == 2'b11);
        cycles    <= cycles + 1;
    end

    // frame decoder and line-change monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (txd !== prev_txd && !seen_tick && !seen_rst) glitches++;
            if (flush_ack != flush_req) begin
                rx_state = 0;
                flush_ack = flush_req;
            end
            if (seen_tick) begin
                if (rx_state == 0) begin
                    if (txd == 1'b0) rx_state = 1;
                end else if (rx_state <= 8) begin
                    rx_sh[rx_state-1] = txd;
                    rx_state++;
                end else begin
                    if (txd == 1'b1) rx_q.push_back(rx_sh);
                    else stop_errs++;
                    rx_state = 0;
                end
            end
        end
        prev_txd = txd;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit accepted);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        if (accepted) exp_q.push_back(b);
    endtask

    task automatic cmd(input logic [1:0] c);
        cmd_valid = 1'b1;
        cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code = 2'b00;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic compare_stream(input string req);
        chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
        for (int i = ck_idx; i < rx_q.size() && i < exp_q.size(); i++)
            chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
        ck_idx = (rx_q.size() < exp_q.size()) ? rx_q.size() : exp_q.size();
    endtask

    always @(posedge clk) begin
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R1: reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_ready == 1'b0 && tx_idle == 1'b0, "R1 flags", {tx_ready, tx_idle}, 0);
        // R2: nop command and R8: write while off
        tick_en = 1'b1;
        cmd(2'b00);
        put(8'h55, 1'b0);
        chk(tx_ready == 1'b0, "R2 nop keeps off", tx_ready, 0);
        // R3
        cmd(2'b01);
        chk(tx_ready && tx_idle, "R3 enable flags", {tx_ready, tx_idle}, 3);
        settle(100);
        compare_stream("R8 write while off");
        chk(tx_idle == 1'b1, "R8 still idle", tx_idle, 1);

        // R7: single write wakes transmitter
        put(8'hA3, 1'b1);
        chk(tx_idle == 1'b0, "R7 idle clears", tx_idle, 0);
        settle(60);
        compare_stream("R7 frame");
        chk(tx_idle == 1'b1, "R6 idle after stop", tx_idle, 1);

        // R5 / R12: fill with ticks held off
        tick_en = 1'b0;
        settle(3);
        for (int i = 0; i < DEPTH; i++) put(8'(8'h10 + i), 1'b1);
        chk(tx_ready == 1'b0, "R5 full drops ready", tx_ready, 0);
        chk(tx_idle == 1'b0, "R6 idle low with data", tx_idle, 0);
        put(8'hEE, 1'b0);
        tick_en = 1'b1;
        t0 = cycles;
        while (!tx_idle && cycles - t0 < 2000) @(negedge clk);
        chk((cycles - t0) >= 10 * DEPTH * TPER && (cycles - t0) <= 10 * DEPTH * TPER + TPER + 2,
            "R12 back-to-back duration", cycles - t0, 10 * DEPTH * TPER);
        settle(2);
        compare_stream("R5 full stream");

        // R4: sweep of all byte values
        for (int b = 0; b < 256; b++) begin
            while (!tx_ready) @(negedge clk);
            put(8'(b), 1'b1);
        end
        while (!tx_idle) @(negedge clk);
        settle(4);
        compare_stream("R4 sweep");

        // R10: graceful disable
        tick_en = 1'b0;
        settle(3);
        put(8'h81, 1'b1);
        put(8'h42, 1'b1);
        put(8'hC3, 1'b1);
        cmd(2'b10);
        chk(!tx_ready && !tx_idle, "R10 flags drop", {tx_ready, tx_idle}, 0);
        put(8'h99, 1'b0);
        tick_en = 1'b1;
        settle(200);
        compare_stream("R10 drain");
        chk(!tx_ready && !tx_idle, "R10 ends disabled", {tx_ready, tx_idle}, 0);
        put(8'h77, 1'b0);
        settle(60);
        compare_stream("R8 write after drain");

        // R11: enable cancels pending disable
        cmd(2'b01);
        tick_en = 1'b0;
        settle(3);
        put(8'h5A, 1'b1);
        put(8'hA5, 1'b1);
        cmd(2'b10);
        cmd(2'b01);
        chk(tx_ready == 1'b1, "R11 ready back", tx_ready, 1);
        put(8'h3C, 1'b1);
        tick_en = 1'b1;
        settle(200);
        compare_stream("R11 stream");
        chk(tx_idle == 1'b1, "R11 still enabled", tx_idle, 1);

        // R9: reset mid-frame
        put(8'h11, 1'b0);
        put(8'h22, 1'b0);
        put(8'h33, 1'b0);
        settle(15);
        tick_en = 1'b0;
        settle(2);
        cmd(2'b11);
        chk(txd == 1'b1, "R9 line high", txd, 1);
        chk(!tx_ready && !tx_idle, "R9 flags clear", {tx_ready, tx_idle}, 0);
        flush_req++;
        settle(2);
        tick_en = 1'b1;
        settle(100);
        cmd(2'b01);
        chk(tx_idle == 1'b1, "R9 queue emptied", tx_idle, 1);
        settle(100);
        compare_stream("R9 no frames");
        chk(txd == 1'b1, "R9 line stays high", txd, 1);

        chk(glitches == 0, "R4 line between ticks", glitches, 0);
        chk(stop_errs == 0, "R4 stop bit", stop_errs, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule